// File: doc/BRIEF.md
# Programmable Read/Write Latency Shim for a Row-Buffered Memory Command Path

The shim sits between the command scheduler of a row-buffered memory controller and the memory command bus. It lets ordinary DRAM pose as a slower non-volatile memory by stretching two timing intervals only. A read column command waits an extra, programmable number of bus cycles after the activate that opened its row. After a row has been written, the precharge that closes it is stretched by a second, independently programmed amount, and the next activate to that bank waits out that window. One delay step equals one bus clock, which is 4 ns at a 250 MHz bus.

Commands flow strictly in order. When the command at the head has to wait, the shim drops its ready output and everything behind it waits too. Because the read penalty is counted from the activate, only the first read into a newly opened row pays it. Later reads to the same open row, for example the rest of a page inside an 8 KB row, pass at full rate. Each delay value is captured when the command that starts its window is accepted. A later change to the configuration inputs therefore never alters a window that is already counting.

Top module: `nvm_lat_shim`

## Requirements
- R1: While rst_ni is low, out_valid_o is low, and every bank comes out of reset with no read or activate hold.
- R2: A command accepted on a rising edge (in_valid_i and in_ready_o both high) appears on the output port on the next edge, with the same type, bank and row, and out_valid_o is high for exactly that one cycle. Command encoding on in_cmd_i and out_cmd_o: 0 activate, 1 read, 2 write, 3 precharge.
- R3: After an activate to bank b is accepted on edge e with rd_dly_i = N, a read to bank b is not accepted before edge e+N+1, and in_ready_o stays low while such a read is held.
- R4: Once the read window of an open row has elapsed, further reads to that bank are accepted with no stall, so the penalty is paid once per activate.
- R5: Writes and precharges are never held, whatever the bank state.
- R6: When a write to bank b was accepted since its last activate, a precharge to b accepted on edge p blocks the next activate to b until edge p+W+1. W is the wr_dly_i value captured by the most recent such write.
- R7: A precharge with no write since the last activate adds no activate delay.
- R8: With both delays zero, a stream of commands is accepted on consecutive edges with no stall.
- R9: The read delay is captured when the activate is accepted and the write delay when the write is accepted. Changing rd_dly_i or wr_dly_i later does not affect a window already started.
- R10: A held command stalls all commands behind it, including commands to other banks, and no command overtakes another.
- R11: Delays are DLY_W = 14 bits wide, and the largest value, 16383, is honoured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_dly_i | input | DLY_W | Extra read delay in cycles, from activate to read |
| wr_dly_i | input | DLY_W | Extra post-write precharge delay in cycles |
| in_valid_i | input | 1 | Scheduler command valid |
| in_ready_o | output | 1 | Shim can take the current command |
| in_cmd_i | input | 2 | Command type (0 activate, 1 read, 2 write, 3 precharge) |
| in_bank_i | input | BANK_W | Target bank |
| in_row_i | input | ROW_W | Row address |
| out_valid_o | output | 1 | Command issued on the memory bus this cycle |
| out_cmd_o | output | 2 | Issued command type |
| out_bank_o | output | BANK_W | Issued bank |
| out_row_o | output | ROW_W | Issued row address |

## Verification
Every accepted command is due on the output one edge after the edge that took it. The bench therefore checks the output at the falling edge that follows acceptance. A held read is due on edge e+N+1 after its activate on edge e, and a held activate is due on edge p+W+1 after its precharge on edge p. The bench counts rising edges and predicts the exact acceptance edge of each command from the delay values present when the opening activate or the write was accepted, then compares that prediction with the observed edge. All inputs are driven on falling edges and in_ready_o is read 1 ns later, so no result hinges on process order at a rising edge.

// File: rtl/nvm_shim_pkg.sv
`timescale 1ns/1ps
package nvm_shim_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;
endpackage

// File: rtl/nvm_bank_timer.sv
`timescale 1ns/1ps
module nvm_bank_timer #(
  parameter int DLY_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             wr_i,
  input  logic             pre_i,
  input  logic [DLY_W-1:0] rd_dly_i,
  input  logic [DLY_W-1:0] wr_dly_i,
  output logic             rd_hold_o,
  output logic             act_hold_o
);
  logic [DLY_W-1:0] rd_cnt_q, pre_cnt_q, wr_lat_q;
  logic             wrote_q;

  // read window: loaded at activate, counted down each cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rd_cnt_q <= '0;
    else if (act_i)           rd_cnt_q <= rd_dly_i;
    else if (rd_cnt_q != '0)  rd_cnt_q <= rd_cnt_q - 1'b1;
  end

  // write delay captured at the write, cleared when the row closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrote_q  <= 1'b0;
      wr_lat_q <= '0;
    end else if (wr_i) begin
      wrote_q  <= 1'b1;
      wr_lat_q <= wr_dly_i;
    end else if (act_i || pre_i) begin
      wrote_q  <= 1'b0;
    end
  end

  // stretched precharge window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_cnt_q <= '0;
    else if (pre_i)           pre_cnt_q <= wrote_q ? wr_lat_q : '0;
    else if (pre_cnt_q != '0) pre_cnt_q <= pre_cnt_q - 1'b1;
  end

  assign rd_hold_o  = (rd_cnt_q != '0);
  assign act_hold_o = (pre_cnt_q != '0);
endmodule

// File: rtl/nvm_cmd_gate.sv
`timescale 1ns/1ps
module nvm_cmd_gate
  import nvm_shim_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 16,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [1:0]           in_cmd_i,
  input  logic [BANK_W-1:0]    in_bank_i,
  input  logic [ROW_W-1:0]     in_row_i,
  input  logic [NUM_BANKS-1:0] rd_hold_i,
  input  logic [NUM_BANKS-1:0] act_hold_i,
  output logic                 in_ready_o,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [NUM_BANKS-1:0] wr_o,
  output logic [NUM_BANKS-1:0] pre_o,
  output logic                 out_valid_o,
  output logic [1:0]           out_cmd_o,
  output logic [BANK_W-1:0]    out_bank_o,
  output logic [ROW_W-1:0]     out_row_o
);
  cmd_e cmd;
  logic held, accept;

  assign cmd = cmd_e'(in_cmd_i);

  always_comb begin
    held = 1'b0;
    unique case (cmd)
      CMD_RD:  held = rd_hold_i[in_bank_i];
      CMD_ACT: held = act_hold_i[in_bank_i];
      default: held = 1'b0;
    endcase
  end

  assign in_ready_o = !held;
  assign accept     = in_valid_i && in_ready_o;

  always_comb begin
    act_o = '0;
    wr_o  = '0;
    pre_o = '0;
    if (accept) begin
      unique case (cmd)
        CMD_ACT: act_o[in_bank_i] = 1'b1;
        CMD_WR:  wr_o[in_bank_i]  = 1'b1;
        CMD_PRE: pre_o[in_bank_i] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_cmd_o   <= '0;
      out_bank_o  <= '0;
      out_row_o   <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        out_cmd_o  <= in_cmd_i;
        out_bank_o <= in_bank_i;
        out_row_o  <= in_row_i;
      end
    end
  end
endmodule

// File: rtl/nvm_lat_shim.sv
`timescale 1ns/1ps
module nvm_lat_shim #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 16,
  parameter int DLY_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DLY_W-1:0]  rd_dly_i,
  input  logic [DLY_W-1:0]  wr_dly_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_cmd_i,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic [ROW_W-1:0]  in_row_i,
  output logic              out_valid_o,
  output logic [1:0]        out_cmd_o,
  output logic [BANK_W-1:0] out_bank_o,
  output logic [ROW_W-1:0]  out_row_o
);
  logic [NUM_BANKS-1:0] rd_hold, act_hold, act_v, wr_v, pre_v;

  nvm_cmd_gate #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)
  ) u_gate (
    .clk_i, .rst_ni, .in_valid_i, .in_cmd_i, .in_bank_i, .in_row_i,
    .rd_hold_i(rd_hold), .act_hold_i(act_hold), .in_ready_o,
    .act_o(act_v), .wr_o(wr_v), .pre_o(pre_v),
    .out_valid_o, .out_cmd_o, .out_bank_o, .out_row_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    nvm_bank_timer #(.DLY_W(DLY_W)) u_timer (
      .clk_i, .rst_ni,
      .act_i(act_v[b]), .wr_i(wr_v[b]), .pre_i(pre_v[b]),
      .rd_dly_i, .wr_dly_i,
      .rd_hold_o(rd_hold[b]), .act_hold_o(act_hold[b])
    );
  end
endmodule

// File: rtl/nvm_lat_shim_chk.sv
`timescale 1ns/1ps
module nvm_lat_shim_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 16,
  parameter int DLY_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DLY_W-1:0]  rd_dly_i,
  input logic [DLY_W-1:0]  wr_dly_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [1:0]        in_cmd_i,
  input logic [BANK_W-1:0] in_bank_i,
  input logic [ROW_W-1:0]  in_row_i,
  input logic              out_valid_o,
  input logic [1:0]        out_cmd_o,
  input logic [BANK_W-1:0] out_bank_o,
  input logic [ROW_W-1:0]  out_row_o
);
  localparam logic [DLY_W:0] SAT = '1;

  logic           acc;
  logic [DLY_W:0] since_act [NUM_BANKS];
  logic [DLY_W:0] since_pre [NUM_BANKS];
  logic [DLY_W-1:0] rd_need [NUM_BANKS];
  logic [DLY_W-1:0] act_need [NUM_BANKS];
  logic [DLY_W-1:0] wlat [NUM_BANKS];
  logic [NUM_BANKS-1:0] wrote;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrote <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_act[b] <= SAT;
        since_pre[b] <= SAT;
        rd_need[b]   <= '0;
        act_need[b]  <= '0;
        wlat[b]      <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (since_act[b] != SAT) since_act[b] <= since_act[b] + 1'b1;
        if (since_pre[b] != SAT) since_pre[b] <= since_pre[b] + 1'b1;
        if (acc && in_bank_i == BANK_W'(b)) begin
          case (in_cmd_i)
            2'd0: begin since_act[b] <= '0; rd_need[b] <= rd_dly_i; wrote[b] <= 1'b0; end
            2'd2: begin wrote[b] <= 1'b1; wlat[b] <= wr_dly_i; end
            2'd3: begin
              since_pre[b] <= '0;
              act_need[b]  <= wrote[b] ? wlat[b] : '0;
              wrote[b]     <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r2_out_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o && out_cmd_o == $past(in_cmd_i) &&
            out_bank_o == $past(in_bank_i) && out_row_o == $past(in_row_i));

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !out_valid_o);

  a_r3_rd_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_cmd_i == 2'd1) |-> since_act[in_bank_i] >= {1'b0, rd_need[in_bank_i]});

  a_r4_rd_free_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_cmd_i == 2'd1 &&
     since_act[in_bank_i] >= {1'b0, rd_need[in_bank_i]}) |-> in_ready_o);

  a_r5_wr_pre_never_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_cmd_i[1]) |-> in_ready_o);

  a_r6_act_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_cmd_i == 2'd0) |-> since_pre[in_bank_i] >= {1'b0, act_need[in_bank_i]});
endmodule

bind nvm_lat_shim nvm_lat_shim_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DLY_W(DLY_W)
) u_chk (.*);

// File: tb/nvm_lat_shim_bench.sv
`timescale 1ns/1ps
module nvm_lat_shim_bench;
  localparam int NB = 8;
  localparam int RW = 16;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] rd_dly = '0, wr_dly = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_cmd = '0;
  logic [2:0]    in_bank = '0;
  logic [RW-1:0] in_row = '0;
  logic          out_valid;
  logic [1:0]    out_cmd;
  logic [2:0]    out_bank;
  logic [RW-1:0] out_row;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  int rd_at [NB];
  int act_at [NB];
  int wlat [NB];
  bit wrote [NB];
  int last_acc;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_lat_shim u_nvm_lat_shim (
    .clk_i(clk), .rst_ni(rst_n), .rd_dly_i(rd_dly), .wr_dly_i(wr_dly),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_cmd_i(in_cmd),
    .in_bank_i(in_bank), .in_row_i(in_row), .out_valid_o(out_valid),
    .out_cmd_o(out_cmd), .out_bank_o(out_bank), .out_row_o(out_row)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Called just after a falling edge; returns at the falling edge after acceptance.
  task automatic send(input int c, input int b, input int r, input string tag);
    int pe, exp_acc, acc;
    pe = cyc + 1;
    case (c)
      1: exp_acc = imax(pe, rd_at[b]);
      0: exp_acc = imax(pe, act_at[b]);
      default: exp_acc = pe;
    endcase
    in_valid = 1'b1; in_cmd = 2'(c); in_bank = 3'(b); in_row = RW'(r);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    in_valid = 1'b0;
    chk(acc == exp_acc, tag, acc, exp_acc);
    chk(out_valid && out_cmd == 2'(c) && out_bank == 3'(b) && out_row == RW'(r),
        "R2 output copy", {out_valid, out_cmd, out_bank, out_row},
        {1'b1, 2'(c), 3'(b), RW'(r)});
    case (c)
      0: begin rd_at[b] = acc + int'(rd_dly) + 1; wrote[b] = 1'b0; end
      2: begin wrote[b] = 1'b1; wlat[b] = int'(wr_dly); end
      3: begin act_at[b] = acc + (wrote[b] ? wlat[b] : 0) + 1; wrote[b] = 1'b0; end
      default: ;
    endcase
    last_acc = acc;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int a0, t0;
    void'($urandom(32'd7741));
    for (int b = 0; b < NB; b++) begin rd_at[b] = 0; act_at[b] = 0; wlat[b] = 0; wrote[b] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_cmd = 2'd1; in_bank = 3'd3; #1;
    chk(in_ready == 1'b1, "R1 read ready after reset", in_ready, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle output", out_valid, 0);

    // R8 zero delays: consecutive edges
    t0 = cyc;
    send(0, 1, 10, "R8 act");
    send(1, 1, 10, "R8 rd");
    send(2, 1, 10, "R8 wr");
    send(3, 1, 10, "R8 pre");
    send(0, 1, 11, "R8 act2");
    chk(last_acc - t0 == 5, "R8 no stall", last_acc - t0, 5);

    // R3 read window and R4 pay once
    rd_dly = 14'd9;
    send(0, 2, 20, "R3 act");
    a0 = last_acc;
    send(1, 2, 20, "R3 held read");
    chk(last_acc - a0 == 10, "R3 read gap", last_acc - a0, 10);
    send(1, 2, 20, "R4 second read");
    chk(last_acc - a0 == 11, "R4 no second penalty", last_acc - a0, 11);

    // R5 write and precharge pass while read window counting; R6 post-write window
    wr_dly = 14'd6;
    send(0, 4, 30, "R5 act");
    send(2, 4, 30, "R5 write not held");
    send(3, 4, 30, "R5 pre not held");
    a0 = last_acc;
    send(0, 4, 31, "R6 act held");
    chk(last_acc - a0 == 7, "R6 act gap", last_acc - a0, 7);

    // R7 precharge without write
    rd_dly = 14'd0;
    send(3, 4, 31, "R7 pre");
    a0 = last_acc;
    send(0, 4, 32, "R7 act");
    chk(last_acc - a0 == 1, "R7 act gap", last_acc - a0, 1);

    // R9 config captured at act / last write
    rd_dly = 14'd6;
    send(0, 5, 40, "R9 act");
    a0 = last_acc;
    rd_dly = 14'd0;
    send(1, 5, 40, "R9 read uses captured delay");
    chk(last_acc - a0 == 7, "R9 read gap", last_acc - a0, 7);
    wr_dly = 14'd2;
    send(2, 5, 40, "R9 wr a");
    wr_dly = 14'd8;
    send(2, 5, 40, "R9 wr b");
    wr_dly = 14'd0;
    send(3, 5, 40, "R9 pre");
    a0 = last_acc;
    send(0, 5, 41, "R9 act after write");
    chk(last_acc - a0 == 9, "R9 last write delay", last_acc - a0, 9);

    // R10 stall blocks other banks
    rd_dly = 14'd12;
    send(0, 6, 50, "R10 act");
    a0 = last_acc;
    rd_dly = 14'd0;
    send(1, 6, 50, "R10 held read");
    send(0, 7, 60, "R10 other bank behind");
    chk(last_acc - a0 == 14, "R10 order", last_acc - a0, 14);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int c, b;
      if ($urandom_range(7) == 0) rd_dly = DW'($urandom_range(15));
      if ($urandom_range(7) == 0) wr_dly = DW'($urandom_range(15));
      c = $urandom_range(3);
      b = $urandom_range(NB - 1);
      case (c)
        0: send(c, b, $urandom_range(65535), "R3 R6 random act");
        1: send(c, b, $urandom_range(65535), "R3 R4 random read");
        default: send(c, b, $urandom_range(65535), "R5 random wr or pre");
      endcase
      if ($urandom_range(3) == 0) @(negedge clk);
    end

    // R11 full-range delay
    rd_dly = 14'd16383;
    send(0, 0, 77, "R11 act");
    a0 = last_acc;
    rd_dly = 14'd0;
    send(1, 0, 77, "R11 max read");
    chk(last_acc - a0 == 16384, "R11 max gap", last_acc - a0, 16384);

    @(negedge clk);
    chk(out_valid == 1'b0, "R2 single cycle valid", out_valid, 0);
    summary();
  end
endmodule